// File: doc/BRIEF.md
# Quadratic Permutation Interleaver Address Generator

This block walks the permutation of a quadratic-polynomial interleaver. For a block of K bits and coefficients f1 and f2, it emits the index (f1·i + f2·i²) mod K for i = 0, 1, …, K-1. It emits one index per accepted handshake. A downstream bit memory uses each index as its read address. The caller looks up the coefficient pair elsewhere and presents it together with K on a one-cycle start pulse. The block size may differ from one block to the next.

No multiplier or divider is used. The block keeps the current index and a running first difference. Each step adds the difference to the index, then adds a constant second difference (2·f2 mod K) to the difference. Both additions reduce modulo K with a single conditional subtraction. Before any address is produced, the size is checked against the legal grid of 188 block sizes. An illegal size raises a flag, and the block produces no addresses.

The coefficients must be below K, which holds for every legal coefficient pair. Example pairs are (K=40, f1=3, f2=10), (K=1024, 31, 64) and (K=6144, 263, 480).

Top module: `qpp_addr_gen`

## Requirements
- R1: One cycle after a start with a legal size, `valid_o` is 1 and `addr_o` is 0. At the n-th accepted handshake (`valid_o` and `advance` both 1, counted from 0), `addr_o` equals (f1·n + f2·n²) mod K.
- R2: Over one block, exactly K handshakes occur. Every address is below K, and no address repeats, so the block is a permutation of 0..K-1.
- R3: A size is legal when it is a multiple of 8 from 40 to 512, a multiple of 16 above 512 up to 1024, a multiple of 32 above 1024 up to 2048, or a multiple of 64 above 2048 up to 6144. That makes 188 sizes in all, and every other value of `cfg_k` is illegal.
- R4: One cycle after a start with an illegal size, `bad_size_o` is 1 and `valid_o` is 0. Both stay that way until the next start. A start with a legal size clears `bad_size_o` in the following cycle.
- R5: While `valid_o` is 1 and `advance` is 0, `addr_o` and `valid_o` keep their values.
- R6: `last_o` is 1 exactly while the address of index K-1 is presented. One cycle after that handshake, `valid_o` is 0, and it stays 0 until the next start.
- R7: A start during a block abandons that block. The generator restarts at index 0 with the newly presented size and coefficients.
- R8: After reset, `valid_o`, `last_o` and `bad_size_o` are 0.
- R9: `cfg_k`, `cfg_f1` and `cfg_f2` are sampled only on a start cycle. Changing them during a block does not alter its addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle pulse that samples the configuration and begins a block |
| cfg_k | input | KW | Block size K |
| cfg_f1 | input | KW | Linear coefficient, below K |
| cfg_f2 | input | KW | Quadratic coefficient, below K |
| advance | input | 1 | Consumer accepts the current address |
| addr_o | output | KW | Permuted index |
| valid_o | output | 1 | Address is valid |
| last_o | output | 1 | Current address is for index K-1 |
| bad_size_o | output | 1 | Sampled size is not on the legal grid |

## Verification
A corrupted difference register does not stay hidden. Every later address of the block is wrong, and the error shows within one or two handshakes. A missed modular reduction pushes `addr_o` to K or above, which the range property catches in the same cycle. An off-by-one in the index counter appears at the end of the block: `last_o` lands on the wrong handshake, or the handshake count differs from K. A wrong size decision shows on `bad_size_o` one cycle after start. The bench sweeps every 13-bit size value to catch it.

// File: rtl/qpp_pkg.sv
`timescale 1ns/1ps
package qpp_pkg;
   typedef enum logic [1:0] {
      GEN_IDLE = 2'd0,
      GEN_RUN  = 2'd1,
      GEN_BAD  = 2'd2
   } gen_state_e;

   // size grid: segment s accepts LO < k <= HI with k a multiple of 2**SH
   localparam int unsigned NUM_SEG = 4;
   localparam int unsigned SEG_LO [NUM_SEG] = '{39, 512, 1024, 2048};
   localparam int unsigned SEG_HI [NUM_SEG] = '{512, 1024, 2048, 6144};
   localparam int unsigned SEG_SH [NUM_SEG] = '{3, 4, 5, 6};
   localparam int unsigned K_LARGEST = 6144;
endpackage

// File: rtl/qpp_size_check.sv
`timescale 1ns/1ps
module qpp_size_check
   import qpp_pkg::*;
#(
   parameter int unsigned KW         = 13,
   parameter bit          CHECK_GRID = 1'b1
) (
   input  logic [KW-1:0] k,
   output logic          legal
);
   generate
      if (CHECK_GRID) begin : g_grid
         logic [NUM_SEG-1:0] seg_ok;
         for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
            localparam logic [KW-1:0] LO   = KW'(SEG_LO[s]);
            localparam logic [KW-1:0] HI   = KW'(SEG_HI[s]);
            localparam logic [KW-1:0] MASK = KW'((1 << SEG_SH[s]) - 1);
            assign seg_ok[s] = (k > LO) && (k <= HI) && ((k & MASK) == '0);
         end
         assign legal = |seg_ok;
      end else begin : g_any
         assign legal = (k > KW'(1));
      end
   endgenerate
endmodule

// File: rtl/qpp_mod_add.sv
`timescale 1ns/1ps
module qpp_mod_add #(
   parameter int unsigned W          = 13,
   parameter bit          BORROW_SEL = 1'b1
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic [W-1:0] m,
   output logic [W-1:0] y
);
   // operands are below m, so one subtraction of m completes the reduction
   logic [W:0] sum;
   assign sum = {1'b0, a} + {1'b0, b};

   generate
      if (BORROW_SEL) begin : g_borrow
         logic [W+1:0] diff;
         logic         unused_top;
         assign diff       = {1'b0, sum} - {2'b00, m};
         assign unused_top = diff[W];
         assign y          = diff[W+1] ? sum[W-1:0] : diff[W-1:0];
      end else begin : g_cmp
         logic [W:0] diff;
         logic       unused_top;
         assign diff       = sum - {1'b0, m};
         assign unused_top = diff[W];
         assign y          = (sum >= {1'b0, m}) ? diff[W-1:0] : sum[W-1:0];
      end
   endgenerate
endmodule

// File: rtl/qpp_ctrl.sv
`timescale 1ns/1ps
module qpp_ctrl
   import qpp_pkg::*;
#(
   parameter int unsigned KW = 13
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          size_ok,
   input  logic [KW-1:0] size_in,
   input  logic          advance,
   output logic          run,
   output logic          bad,
   output logic          last,
   output logic          step
);
   gen_state_e    st;
   logic [KW-1:0] idx;
   logic [KW-1:0] top_idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= GEN_IDLE;
         idx     <= '0;
         top_idx <= '0;
      end else if (start) begin
         st      <= size_ok ? GEN_RUN : GEN_BAD;
         idx     <= '0;
         top_idx <= size_in - KW'(1);
      end else if (st == GEN_RUN && advance) begin
         if (idx == top_idx) st <= GEN_IDLE;
         else                idx <= idx + KW'(1);
      end
   end

   assign run  = (st == GEN_RUN);
   assign bad  = (st == GEN_BAD);
   assign last = run && (idx == top_idx);
   assign step = run && advance;
endmodule

// File: rtl/qpp_addr_gen.sv
`timescale 1ns/1ps
module qpp_addr_gen
   import qpp_pkg::*;
#(
   parameter int unsigned KW         = 13,
   parameter bit          CHECK_GRID = 1'b1,
   parameter bit          BORROW_SEL = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [KW-1:0] cfg_k,
   input  logic [KW-1:0] cfg_f1,
   input  logic [KW-1:0] cfg_f2,
   input  logic          advance,
   output logic [KW-1:0] addr_o,
   output logic          valid_o,
   output logic          last_o,
   output logic          bad_size_o
);
   generate
      if (KW < 4) begin : g_kw_small
         $error("qpp_addr_gen: KW must be at least 4");
      end
      if (CHECK_GRID && ((64'd1 << KW) <= 64'(K_LARGEST))) begin : g_kw_grid
         $error("qpp_addr_gen: KW too narrow for the size grid");
      end
   endgenerate

   logic [KW-1:0] k_q, d_q, pi_q, g_q;
   logic [KW-1:0] g0, d0, pi_nx, g_nx;
   logic          size_ok, step, load;

   qpp_size_check #(.KW(KW), .CHECK_GRID(CHECK_GRID)) u_size (
      .k(cfg_k), .legal(size_ok)
   );

   // start values: first difference and constant second difference
   qpp_mod_add #(.W(KW), .BORROW_SEL(BORROW_SEL)) u_g0 (
      .a(cfg_f1), .b(cfg_f2), .m(cfg_k), .y(g0)
   );
   qpp_mod_add #(.W(KW), .BORROW_SEL(BORROW_SEL)) u_d0 (
      .a(cfg_f2), .b(cfg_f2), .m(cfg_k), .y(d0)
   );
   // per-step recurrence
   qpp_mod_add #(.W(KW), .BORROW_SEL(BORROW_SEL)) u_pi (
      .a(pi_q), .b(g_q), .m(k_q), .y(pi_nx)
   );
   qpp_mod_add #(.W(KW), .BORROW_SEL(BORROW_SEL)) u_g (
      .a(g_q), .b(d_q), .m(k_q), .y(g_nx)
   );

   qpp_ctrl #(.KW(KW)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .size_ok(size_ok),
      .size_in(cfg_k), .advance(advance), .run(valid_o), .bad(bad_size_o),
      .last(last_o), .step(step)
   );

   assign load = start && size_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         k_q  <= '0;
         d_q  <= '0;
         g_q  <= '0;
         pi_q <= '0;
      end else if (load) begin
         k_q  <= cfg_k;
         d_q  <= d0;
         g_q  <= g0;
         pi_q <= '0;
      end else if (step) begin
         pi_q <= pi_nx;
         g_q  <= g_nx;
      end
   end

   assign addr_o = pi_q;
endmodule

// File: rtl/qpp_addr_gen_chk.sv
`timescale 1ns/1ps
module qpp_addr_gen_chk #(
   parameter int unsigned KW = 13
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic          advance,
   input logic [KW-1:0] addr_o,
   input logic          valid_o,
   input logic          last_o,
   input logic          bad_size_o,
   input logic [KW-1:0] k_lat
);
   // R2
   addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> addr_o < k_lat);
   // R1
   start_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (valid_o ^ bad_size_o) && (!valid_o || addr_o == '0));
   // R5
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o && !advance && !start |=> valid_o && $stable(addr_o));
   // R6
   last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      last_o |-> valid_o);
   // R6
   last_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      last_o && advance && !start |=> !valid_o);
   // R6
   idle_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_o && !start |=> !valid_o);
   // R4
   bad_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bad_size_o |-> !valid_o);
   // R4
   bad_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bad_size_o && !start |=> bad_size_o);
endmodule

bind qpp_addr_gen qpp_addr_gen_chk #(.KW(KW)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .advance(advance),
   .addr_o(addr_o), .valid_o(valid_o), .last_o(last_o),
   .bad_size_o(bad_size_o), .k_lat(k_q)
);

// File: tb/tb_qpp_addr_gen.sv
`timescale 1ns/1ps
module tb_qpp_addr_gen;
   localparam int KW = 13;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          advance = 1'b0;
   logic [KW-1:0] cfg_k = '0, cfg_f1 = '0, cfg_f2 = '0;
   logic [KW-1:0] addr_o;
   logic          valid_o, last_o, bad_size_o;

   int total = 0;
   int bad   = 0;
   int cyc   = 0;
   logic [15:0] lf = 16'hACE1;
   bit seen [0:8191];

   qpp_addr_gen #(.KW(KW)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .cfg_k(cfg_k),
      .cfg_f1(cfg_f1), .cfg_f2(cfg_f2), .advance(advance),
      .addr_o(addr_o), .valid_o(valid_o), .last_o(last_o),
      .bad_size_o(bad_size_o)
   );

   always #10 clk = ~clk;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 190000) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=<190000", cyc);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic bit legal_size(input int k);
      return (k >= 40   && k <= 512  && k % 8  == 0) ||
             (k >  512  && k <= 1024 && k % 16 == 0) ||
             (k >  1024 && k <= 2048 && k % 32 == 0) ||
             (k >  2048 && k <= 6144 && k % 64 == 0);
   endfunction

   // runs one full block; ok reports a fully correct address sequence
   task automatic run_block(input int k, input int f1, input int f2, input bit stall, output bit ok);
      int cnt = 0, mism = 0, lastbad = 0, dup = 0, holdbad = 0, guard = 0;
      logic adv;
      logic prev_stall = 1'b0;
      logic [KW-1:0] prev_addr = '0;
      @(negedge clk);
      cfg_k = KW'(k); cfg_f1 = KW'(f1); cfg_f2 = KW'(f2);
      start = 1'b1; advance = 1'b0;
      @(negedge clk);
      start = 1'b0;
      // R9: scramble the configuration inputs after the start cycle
      cfg_k = KW'(k + 8); cfg_f1 = KW'(f1 + 5); cfg_f2 = KW'(f2 + 3);
      check(valid_o === 1'b1 && addr_o === '0, "R1 first address", addr_o, 0);
      check(bad_size_o === 1'b0, "R4 legal start clears flag", bad_size_o, 0);
      foreach (seen[j]) seen[j] = 1'b0;
      while (cnt < k && guard < 4 * k + 10) begin
         guard++;
         if (valid_o !== 1'b1) break;
         if (prev_stall && addr_o !== prev_addr) holdbad++;
         adv = stall ? lf[0] : 1'b1;
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         if (last_o !== (cnt == k - 1)) lastbad++;
         if (adv) begin
            longint e;
            e = (longint'(f1) * cnt + longint'(f2) * cnt * cnt) % k;
            if (longint'(addr_o) != e) mism++;
            if (int'(addr_o) >= k || seen[addr_o]) dup++;
            else seen[addr_o] = 1'b1;
            cnt++;
         end
         prev_stall = !adv;
         prev_addr  = addr_o;
         advance = adv;
         @(negedge clk);
      end
      advance = 1'b0;
      check(mism == 0, "R1 direct formula", mism, 0);
      check(cnt == k, "R2 handshake count", cnt, k);
      check(dup == 0, "R2 permutation", dup, 0);
      check(lastbad == 0, "R6 last position", lastbad, 0);
      check(valid_o === 1'b0, "R6 valid drops after last", valid_o, 0);
      if (stall) check(holdbad == 0, "R5 hold under stall", holdbad, 0);
      repeat (5) @(negedge clk);
      check(valid_o === 1'b0, "R6 idle until start", valid_o, 0);
      ok = (mism == 0) && (cnt == k) && (dup == 0);
   endtask

   initial begin
      bit ok;
      int nlegal = 0, sizebad = 0;
      repeat (3) @(negedge clk);
      // R8
      check(valid_o === 1'b0 && last_o === 1'b0 && bad_size_o === 1'b0,
            "R8 reset state", {valid_o, last_o, bad_size_o}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 R2 R6 R9: several sizes, smallest and largest included
      run_block(40,   3,   10,  1'b0, ok);
      run_block(48,   7,   12,  1'b0, ok);
      run_block(512,  31,  64,  1'b0, ok);
      run_block(1024, 31,  64,  1'b0, ok);
      run_block(1056, 17,  66,  1'b0, ok);
      run_block(2112, 17,  66,  1'b0, ok);
      run_block(6144, 263, 480, 1'b0, ok);
      // R5: random stalls
      run_block(1024, 31,  64,  1'b1, ok);
      run_block(40,   3,   10,  1'b1, ok);

      // R4: illegal size
      @(negedge clk);
      cfg_k = 13'd44; cfg_f1 = 13'd3; cfg_f2 = 13'd10; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(bad_size_o === 1'b1 && valid_o === 1'b0, "R4 illegal flagged",
            {bad_size_o, valid_o}, 2);
      advance = 1'b1;
      repeat (20) @(negedge clk);
      advance = 1'b0;
      check(bad_size_o === 1'b1 && valid_o === 1'b0, "R4 illegal held",
            {bad_size_o, valid_o}, 2);

      // R7: restart mid-block with a new configuration
      @(negedge clk);
      cfg_k = 13'd1024; cfg_f1 = 13'd31; cfg_f2 = 13'd64; start = 1'b1;
      @(negedge clk);
      start = 1'b0; advance = 1'b1;
      repeat (10) @(negedge clk);
      advance = 1'b0;
      run_block(48, 7, 12, 1'b0, ok);
      check(ok, "R7 restart sequence", ok, 1);

      // R3: sweep every size value; each start restarts the previous one
      for (int k = 0; k < 8192; k++) begin
         @(negedge clk);
         cfg_k = KW'(k); cfg_f1 = '0; cfg_f2 = '0; start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         if (valid_o === 1'b1) nlegal++;
         if (valid_o !== legal_size(k) || bad_size_o !== !legal_size(k)) sizebad++;
      end
      check(sizebad == 0, "R3 size grid decisions", sizebad, 0);
      check(nlegal == 188, "R3 legal size count", nlegal, 188);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule